// File: doc/BRIEF.md
# Prescaled Microsecond Tick Timer Pair

This block gives software two 32-bit tick timers that advance at a fixed 1 µs rate, taken from the bus clock. Both timers share one 8-bit prescaler. Software loads the prescaler's adjust register with 256 minus the bus clock frequency in MHz. The prescaler then issues a one-clock tick enable every (256 − adjust) clocks.

Each timer has a compare word, a counter word and a control byte, all reached over a byte-wide write/read port. When a timer is enabled, its counter advances once per tick. When the counter equals the compare word at a tick, the timer records a match. A match bumps a saturating 4-bit match count, which software reads back in the upper half of the control byte. It also fires a one-clock pulse toward an external interrupt controller. In wrap mode, the counter returns to zero on that tick instead of advancing.

Byte map with the default parameters:

| Address | Content |
|---|---|
| 0x00–0x03 | timer 0 compare |
| 0x04–0x07 | timer 0 counter |
| 0x08–0x0B | timer 1 compare |
| 0x0C–0x0F | timer 1 counter |
| 0x10 | prescaler adjust |
| 0x11 | timer 0 control |
| 0x12 | timer 1 control |

Within a word, the lowest address holds bits 31:24.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset, every compare, counter, control and adjust register reads 0x00.
- R2: Compare and counter are 32-bit words at 4-byte-aligned addresses, placed as in the byte map above. Word offset 0 holds bits 31:24 and offset 3 holds bits 7:0. A byte write changes only its own byte, and reads return the stored byte.
- R3: The prescaler is an 8-bit up-counter. It emits a tick in the clock where it holds 255 and then reloads from the adjust value. Ticks therefore repeat every (256 − adjust) clocks, so an adjust of 255 gives a tick on every clock.
- R4: Control bit 0 is the enable. While it is 0, the counter keeps its value.
- R5: While enabled, the counter increments by one on each tick.
- R6: Control bit 1 selects wrap mode. In wrap mode, a tick that finds counter equal to compare loads zero. With the bit clear, that tick increments the counter past the compare value.
- R7: Control bits 7:4 hold a count of matches, meaning ticks in which an enabled counter equals compare. The count saturates at 15.
- R8: Writing control with bit 2 set clears the match count in that write. Bit 2 and bit 3 always read as 0.
- R9: A counter byte write in the same clock as a tick increment wins: the written byte is stored, and the other bytes keep their values without incrementing.
- R10: Each match drives that timer's match output high for exactly the one clock after the matching edge, in wrap mode or not.
- R11: The two timers are independent. Writes and counting in one leave the other's registers and match output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the byte at addr |
| addr | input | ADDR_W (5) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| tmr_match | output | N_TMR (2) | One-clock match pulse per timer |

## Verification
Reads are combinational, so a register's value is due in the same cycle its address is presented. The bench samples it a quarter period after the falling edge. Write effects land on the rising edge after the strobe is raised, and each counter step lands on the rising edge of a tick clock. With adjust at 255, an enable window of N edges therefore yields exactly N increments. The window is opened and closed by control writes whose edges the bench counts one by one. A match pulse is high during the clock after its matching edge. The bench counts it at falling edges, and compares the count only after the timer is disabled again.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam int BYTE_W      = 8;
    localparam int MCNT_W      = 4;
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_WRAP_BIT = 1;
    localparam int CTL_CLR_BIT = 2;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adj_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] adj_o,
    output logic              tick_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] cnt;
        logic [BYTE_W-1:0] adj;
    } pre_state_t;

    pre_state_t st_d, st_q;

    assign tick_o = (st_q.cnt == '1);
    assign adj_o  = st_q.adj;

    always_comb begin
        st_d = st_q;
        if (adj_wr) st_d.adj = wdata;
        if (tick_o) st_d.cnt = st_q.adj;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (st_q.cnt == $past(st_q.adj))); // R3
endmodule

// File: rtl/tt_channel.sv
module tt_channel
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [CNT_W/BYTE_W-1:0]  cmp_wr,
    input  logic [CNT_W/BYTE_W-1:0]  cnt_wr,
    input  logic                     ctl_wr,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [CNT_W-1:0]         cmp_o,
    output logic [CNT_W-1:0]         cnt_o,
    output logic [BYTE_W-1:0]        ctl_o,
    output logic                     match_o
);
    localparam int LANES = CNT_W / BYTE_W;

    typedef struct packed {
        logic              en;
        logic              wrap;
        logic [MCNT_W-1:0] mcnt;
        logic              match;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cmp;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      hit;

    assign hit     = tick && st_q.en && (st_q.cnt == st_q.cmp);
    assign cmp_o   = st_q.cmp;
    assign cnt_o   = st_q.cnt;
    assign match_o = st_q.match;
    assign ctl_o   = {st_q.mcnt, 1'b0, 1'b0, st_q.wrap, st_q.en};

    always_comb begin
        st_d       = st_q;
        st_d.match = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (cmp_wr[l]) st_d.cmp[l*BYTE_W +: BYTE_W] = wdata;
        end
        if (tick && st_q.en) begin
            if (st_q.wrap && hit) st_d.cnt = '0;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
        if (hit) begin
            st_d.match = 1'b1;
            if (st_q.mcnt != '1) st_d.mcnt = st_q.mcnt + 1'b1;
        end
        if (|cnt_wr) begin
            st_d.cnt = st_q.cnt;
            for (int l = 0; l < LANES; l++) begin
                if (cnt_wr[l]) st_d.cnt[l*BYTE_W +: BYTE_W] = wdata;
            end
        end
        if (ctl_wr) begin
            st_d.en   = wdata[CTL_EN_BIT];
            st_d.wrap = wdata[CTL_WRAP_BIT];
            if (wdata[CTL_CLR_BIT]) st_d.mcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && cnt_wr == '0) |=> (cnt_o == $past(cnt_o))); // R4
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && st_q.wrap && cnt_wr == '0) |=> (cnt_o == '0)); // R6
    AST_MCNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mcnt == '1 && !(ctl_wr && wdata[CTL_CLR_BIT])) |=> (st_q.mcnt == '1)); // R7
    AST_MCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[CTL_CLR_BIT]) |=> (st_q.mcnt == '0)); // R8
    AST_PULSE_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(hit)); // R10
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
    import tick_timer_pkg::*;
#(
    parameter int N_TMR  = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [N_TMR-1:0]  tmr_match
);
    localparam int LANES    = CNT_W / BYTE_W;
    localparam int SPAN     = 2 * LANES;
    localparam int ADJ_ADDR = N_TMR * SPAN;
    localparam int STRB_PER = SPAN + 1;
    localparam int STRB_W   = N_TMR * STRB_PER + 1;

    logic [CNT_W-1:0]  cmp_v [N_TMR];
    logic [CNT_W-1:0]  cnt_v [N_TMR];
    logic [BYTE_W-1:0] ctl_v [N_TMR];
    logic [BYTE_W-1:0] adj_v;
    logic              tick;
    logic              adj_wr;
    logic [STRB_W-1:0] wr_vec;

    assign adj_wr = wr_en && (addr == ADDR_W'(ADJ_ADDR));
    assign wr_vec[STRB_W-1] = adj_wr;

    tt_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .adj_wr (adj_wr),
        .wdata  (wdata),
        .adj_o  (adj_v),
        .tick_o (tick)
    );

    for (genvar c = 0; c < N_TMR; c++) begin : g_ch
        localparam int CMP_BASE = c * SPAN;
        localparam int CNT_BASE = CMP_BASE + LANES;
        localparam int CTL_ADDR = ADJ_ADDR + 1 + c;
        logic [LANES-1:0] cmp_wr;
        logic [LANES-1:0] cnt_wr;
        logic             ctl_wr;

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign cmp_wr[l] = wr_en && (addr == ADDR_W'(CMP_BASE + LANES - 1 - l));
            assign cnt_wr[l] = wr_en && (addr == ADDR_W'(CNT_BASE + LANES - 1 - l));
        end
        assign ctl_wr = wr_en && (addr == ADDR_W'(CTL_ADDR));
        assign wr_vec[c*STRB_PER +: STRB_PER] = {ctl_wr, cnt_wr, cmp_wr};

        tt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .cmp_wr  (cmp_wr),
            .cnt_wr  (cnt_wr),
            .ctl_wr  (ctl_wr),
            .wdata   (wdata),
            .cmp_o   (cmp_v[c]),
            .cnt_o   (cnt_v[c]),
            .ctl_o   (ctl_v[c]),
            .match_o (tmr_match[c])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADJ_ADDR)) rdata = adj_v;
        for (int c = 0; c < N_TMR; c++) begin
            if (addr == ADDR_W'(ADJ_ADDR + 1 + c)) rdata = ctl_v[c];
            for (int o = 0; o < LANES; o++) begin
                if (addr == ADDR_W'(c*SPAN + o))
                    rdata = cmp_v[c][(LANES-1-o)*BYTE_W +: BYTE_W];
                if (addr == ADDR_W'(c*SPAN + LANES + o))
                    rdata = cnt_v[c][(LANES-1-o)*BYTE_W +: BYTE_W];
            end
        end
    end

    AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec)); // R2
endmodule

// File: tb/tb_tick_timer_pair.sv
module tb_tick_timer_pair;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam logic [AW-1:0] T0_CMP = 5'h00, T0_CNT = 5'h04;
    localparam logic [AW-1:0] T1_CMP = 5'h08, T1_CNT = 5'h0C;
    localparam logic [AW-1:0] ADJ = 5'h10, CTL0 = 5'h11, CTL1 = 5'h12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic [1:0]    tmr_match;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer_pair dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tmr_match(tmr_match)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [7:0]    exp;
        string         tag;
    } item_t;

    item_t sbq[$];
    event  chk_ev;
    int    vectors = 0;
    int    miscompares = 0;
    int    pulses0 = 0;
    int    pulses1 = 0;
    bit    done = 0;

    function automatic void check(int got, int exp, string tag);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (tmr_match[0]) pulses0++;
            if (tmr_match[1]) pulses1++;
        end
    end

    initial begin
        forever begin
            item_t it;
            @(chk_ev);
            it = sbq.pop_front();
            check(int'(rdata), int'(it.exp), $sformatf("%s @0x%0h", it.tag, it.a));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr32(logic [AW-1:0] base, logic [31:0] v);
        for (int o = 0; o < 4; o++) wr(base + AW'(o), v[(3-o)*8 +: 8]);
    endtask

    task automatic rd(logic [AW-1:0] a, logic [7:0] exp, string tag);
        item_t it;
        addr = a;
        it.a = a; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        #(CLK_PERIOD/4);
        ->chk_ev;
        @(negedge clk);
    endtask

    task automatic rd32(logic [AW-1:0] base, logic [31:0] exp, string tag);
        for (int o = 0; o < 4; o++) rd(base + AW'(o), exp[(3-o)*8 +: 8], tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int b0, b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CTL0, 8'h00, "R1 ctl0");
        rd(CTL1, 8'h00, "R1 ctl1");
        rd(ADJ, 8'h00, "R1 adjust");
        rd32(T0_CNT, 32'h0, "R1 cnt0");
        rd32(T1_CMP, 32'h0, "R1 cmp1");

        // R2 byte order and lane isolation
        wr32(T0_CMP, 32'hA1B2C3D4);
        rd32(T0_CMP, 32'hA1B2C3D4, "R2 cmp0 word");
        wr(T0_CMP + 5'd2, 8'h5E);
        rd32(T0_CMP, 32'hA1B25ED4, "R2 single byte");
        rd32(T1_CMP, 32'h0, "R11 cmp1 untouched");

        // R3 adjust 255: tick every clock
        wr(ADJ, 8'hFF);
        rd(ADJ, 8'hFF, "R3 adjust readback");
        idle(300);

        // R4 hold while disabled
        idle(50);
        rd32(T0_CNT, 32'h0, "R4 hold");

        // R5 ten enabled edges
        wr(CTL0, 8'h01);
        idle(9);
        wr(CTL0, 8'h00);
        rd32(T0_CNT, 32'd10, "R5 count");

        // R3 adjust 252: one tick per four clocks, 20 edges -> 5
        wr32(T0_CNT, 32'h0);
        wr(ADJ, 8'd252);
        idle(3);
        wr(CTL0, 8'h01);
        idle(19);
        wr(CTL0, 8'h00);
        rd32(T0_CNT, 32'd5, "R3 divided tick");
        wr(ADJ, 8'hFF);
        idle(8);

        // R6 R10 wrap mode, compare 3, ten edges
        wr32(T0_CNT, 32'h0);
        wr32(T0_CMP, 32'd3);
        wr(CTL0, 8'h04);
        b0 = pulses0;
        wr(CTL0, 8'h03);
        idle(9);
        wr(CTL0, 8'h02);
        rd32(T0_CNT, 32'd2, "R6 wrap count");
        rd(CTL0, 8'h22, "R7 two matches");
        check(pulses0 - b0, 2, "R10 pulses in wrap mode");

        // R7 saturation: compare 0, wrap, 20 matches
        wr32(T0_CNT, 32'h0);
        wr32(T0_CMP, 32'h0);
        wr(CTL0, 8'h04);
        wr(CTL0, 8'h03);
        idle(19);
        wr(CTL0, 8'h02);
        rd(CTL0, 8'hF2, "R7 saturate");
        rd32(T0_CNT, 32'h0, "R6 stays zero");

        // R8 clear, bits 2 and 3 read zero
        wr(CTL0, 8'h0C);
        rd(CTL0, 8'h00, "R8 clear");

        // R6 R10 no wrap: compare 2, six edges
        wr32(T0_CMP, 32'd2);
        wr32(T0_CNT, 32'h0);
        b0 = pulses0;
        wr(CTL0, 8'h01);
        idle(5);
        wr(CTL0, 8'h00);
        rd32(T0_CNT, 32'd6, "R6 runs past compare");
        rd(CTL0, 8'h10, "R7 one match");
        check(pulses0 - b0, 1, "R10 pulse without wrap");

        // R9 write beats increment
        wr32(T0_CMP, 32'hFFFF0000);
        wr32(T0_CNT, 32'h0);
        wr(CTL0, 8'h01);
        idle(2);
        wr(T0_CNT + 5'd3, 8'h80);
        wr(CTL0, 8'h00);
        rd32(T0_CNT, 32'h81, "R9 write priority");

        // R11 timer 1 alone, compare 0, seven edges
        b0 = pulses0;
        b1 = pulses1;
        wr(CTL1, 8'h01);
        idle(6);
        wr(CTL1, 8'h00);
        rd32(T1_CNT, 32'd7, "R11 cnt1");
        rd(CTL1, 8'h10, "R11 ctl1");
        rd32(T0_CNT, 32'h81, "R11 cnt0 unchanged");
        rd(CTL0, 8'h10, "R11 ctl0 unchanged");
        check(pulses1 - b1, 1, "R11 pulse1");
        check(pulses0 - b0, 0, "R11 no pulse0");

        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule